// File: doc/BRIEF.md
# Preamble-Gated Bit Error Counter with Sample Slicer

This block sits at the receive end of a test link that carries a pseudo-random bit pattern. Every clock it takes one 14-bit converter sample and turns it into a single bit. A software-visible mode pin picks one of two slicers: a magnitude comparison against a programmable reference level, or a plain read of the sample's top bit. Before any error counting starts, the block expects a fixed 4-bit start word from the far end. A wrong word raises an error indicator and asks the sender to repeat the start word. Too many wrong words in a row declare the channel broken.

Once a start word has matched, the block waits for a load strobe. On that strobe it seeds its own 4-bit pattern generator with a fixed constant. It also emits a one-cycle pulse that tells the transmitter to load the same constant. From the next cycle on, every sliced bit is compared with the local generator's top bit, and each disagreement adds one to a saturating error count.

Top module: `prbs_link_rx`

## Requirements
- R1: With `sign_mode` low, the sliced bit is 1 exactly when `adc_sample` is greater than `ref_level`, both read as unsigned numbers; equal gives 0.
- R2: With `sign_mode` high, the sliced bit is `adc_sample[13]`, whatever `ref_level` holds.
- R3: The controller leaves its idle state on the first clock after reset. It then gathers sliced bits in windows of four, the first bit gathered ending up as the most significant bit, and compares each window with the start word 4'b1011.
- R4: A matching window sets `pattern_ok` and clears `pattern_err`, visible after the clock that took the fourth bit; `pattern_ok` and `pattern_err` are never high together.
- R5: A non-matching window sets `pattern_err`, clears `pattern_ok`, raises `retx_req` for exactly one cycle, and the next window starts on the very next bit.
- R6: The fifth failed window since reset sets `chan_fault` without raising `retx_req`. `chan_fault` then holds until reset, and no later window can set `pattern_ok`.
- R7: Reset clears all outputs, the error count and the failed-window tally.
- R8: `load_req` acts only after a matching window and before the first load. It produces a `tx_seed_load` pulse of exactly one cycle on the following clock, loads the local generator with 4'b1000 and clears `err_count`. In every other state it is ignored and produces no pulse.
- R9: The local generator shifts left each counting cycle, with new LSB = bit3 XOR bit0. The reference bit is its bit 3, so the first compared bit after a load is seed bit 3 (1).
- R10: In the counting state, `err_count` rises by one on the clock after each sliced bit that differs from the reference bit. It stays at 2^ERR_W-1 once there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_sample | input | 14 | Converter sample |
| ref_level | input | 14 | Threshold for the comparison slicer |
| sign_mode | input | 1 | 1 selects the top-bit slicer, 0 the comparison slicer |
| load_req | input | 1 | Seed load strobe |
| pattern_ok | output | 1 | Last start window matched |
| pattern_err | output | 1 | Last start window did not match |
| retx_req | output | 1 | One-cycle request to resend the start word |
| chan_fault | output | 1 | Too many failed windows; sticky |
| tx_seed_load | output | 1 | One-cycle pulse telling the transmitter to load its seed |
| err_count | output | ERR_W | Saturating bit error count |

## Verification
On every cycle, the embedded properties check these rules: the two pattern indicators are exclusive, the resend request and the seed pulse last one cycle, the seed pulse follows a waiting state, a fault is sticky and never comes with a resend request, the generator never reaches all zeros, and the count moves by at most one, never backwards, except on a clear. The directed scenarios show the rest. These are the slicer decisions at and around the threshold and in top-bit mode, and the bit order of the start window. They also cover the exact fifth-failure boundary, the reset of the failure tally, the loads that are ignored, and the bit-exact agreement of the reference sequence over a full period. They end with saturation of a narrowed counter.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_PREAMBLE  = 3'd1,
      ST_WAIT_LOAD = 3'd2,
      ST_COUNT     = 3'd3,
      ST_FAULT     = 3'd4
   } rx_state_t;

endpackage

// File: rtl/lnk_slicer.sv
module lnk_slicer #(
   parameter int SAMPLE_W = 14
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] level,
   input  logic                sign_mode,
   output logic                bit_out
);

   localparam int SIGN_POS = SAMPLE_W - 1;

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("lnk_slicer: SAMPLE_W must be at least 2");
      end
   endgenerate

   logic above;
   logic sign_bit;

   assign above    = (sample > level);
   assign sign_bit = sample[SIGN_POS];

   always_comb begin
      if (sign_mode) bit_out = sign_bit;
      else           bit_out = above;
   end

   always_comb begin
      if (!sign_mode && (sample <= level)) begin
         AST_SLICE_LOW: assert (!bit_out); // R1
      end
   end

endmodule

// File: rtl/lnk_preamble_fsm.sv
module lnk_preamble_fsm
   import lnk_pkg::*;
#(
   parameter int          PRE_W     = 4,
   parameter logic [PRE_W-1:0] PATTERN = 4'b1011,
   parameter int          MAX_FAILS = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_in,
   input  logic      load_req,
   output rx_state_t state,
   output logic      load_fire,
   output logic      run,
   output logic      pattern_ok,
   output logic      pattern_err,
   output logic      retx_req,
   output logic      seed_load
);

   localparam int CNT_W  = (PRE_W > 1) ? $clog2(PRE_W) : 1;
   localparam int FAIL_W = $clog2(MAX_FAILS + 1);
   localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(PRE_W - 1);
   localparam logic [FAIL_W-1:0] FAIL_LIM  = FAIL_W'(MAX_FAILS);

   generate
      if (PRE_W < 2) begin : g_bad_pre
         $error("lnk_preamble_fsm: PRE_W must be at least 2");
      end
      if (MAX_FAILS < 1) begin : g_bad_fails
         $error("lnk_preamble_fsm: MAX_FAILS must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0]  window_q;
   logic [PRE_W-1:0]  window_next;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [FAIL_W-1:0] fails_q;
   logic              window_done;
   logic              window_match;

   assign window_next  = {window_q[PRE_W-2:0], bit_in};
   assign window_done  = (state == ST_PREAMBLE) && (bit_cnt_q == LAST_BIT);
   assign window_match = (window_next == PATTERN);
   assign load_fire    = (state == ST_WAIT_LOAD) && load_req;
   assign run          = (state == ST_COUNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         window_q    <= '0;
         bit_cnt_q   <= '0;
         fails_q     <= '0;
         pattern_ok  <= 1'b0;
         pattern_err <= 1'b0;
         retx_req    <= 1'b0;
         seed_load   <= 1'b0;
      end else begin
         retx_req  <= 1'b0;
         seed_load <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               bit_cnt_q <= '0;
               state     <= ST_PREAMBLE;
            end
            ST_PREAMBLE: begin
               window_q <= window_next;
               if (window_done) begin
                  bit_cnt_q <= '0;
                  if (window_match) begin
                     pattern_ok  <= 1'b1;
                     pattern_err <= 1'b0;
                     state       <= ST_WAIT_LOAD;
                  end else begin
                     pattern_ok  <= 1'b0;
                     pattern_err <= 1'b1;
                     if (fails_q == FAIL_LIM) begin
                        state <= ST_FAULT;
                     end else begin
                        fails_q  <= fails_q + 1'b1;
                        retx_req <= 1'b1;
                     end
                  end
               end else begin
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end
            end
            ST_WAIT_LOAD: begin
               if (load_req) begin
                  seed_load <= 1'b1;
                  state     <= ST_COUNT;
               end
            end
            ST_COUNT: state <= ST_COUNT;
            ST_FAULT: state <= ST_FAULT;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   AST_OK_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pattern_ok && pattern_err)); // R4

   AST_RETX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      retx_req |=> !retx_req); // R5

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAULT) |=> (state == ST_FAULT)); // R6

   AST_FAULT_NO_RETX: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAULT) |-> !retx_req); // R6

   AST_SEED_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |-> ($past(state) == ST_WAIT_LOAD)); // R8

   AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> !seed_load); // R8

endmodule

// File: rtl/lnk_lfsr.sv
module lnk_lfsr #(
   parameter int             WIDTH    = 4,
   parameter logic [WIDTH-1:0] TAP_MASK = 4'b1001,
   parameter logic [WIDTH-1:0] SEED     = 4'b1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic advance,
   output logic ref_bit
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lnk_lfsr: WIDTH must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("lnk_lfsr: SEED must be non-zero");
      end
      if (!TAP_MASK[WIDTH-1]) begin : g_bad_taps
         $error("lnk_lfsr: TAP_MASK must include the top stage");
      end
   endgenerate

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] tapped;
   logic             feedback;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_tap
         assign tapped[gi] = state_q[gi] & TAP_MASK[gi];
      end
   endgenerate

   assign feedback = ^tapped;
   assign ref_bit  = state_q[MSB];

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= SEED;
      else if (load)    state_q <= SEED;
      else if (advance) state_q <= {state_q[WIDTH-2:0], feedback};
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0); // R9

   AST_LFSR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ref_bit == SEED[MSB])); // R9

endmodule

// File: rtl/lnk_err_counter.sv
module lnk_err_counter #(
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [ERR_W-1:0] count
);

   localparam logic [ERR_W-1:0] CNT_MAX = '1;

   generate
      if (ERR_W < 2) begin : g_bad_width
         $error("lnk_err_counter: ERR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                        count <= '0;
      else if (clr)                      count <= '0;
      else if (inc && (count != CNT_MAX)) count <= count + 1'b1;
   end

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> (count >= $past(count))); // R10

   AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> ((count - $past(count)) <= ERR_W'(1))); // R10

endmodule

// File: rtl/prbs_link_rx.sv
module prbs_link_rx
   import lnk_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int ERR_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] adc_sample,
   input  logic [SAMPLE_W-1:0] ref_level,
   input  logic                sign_mode,
   input  logic                load_req,
   output logic                pattern_ok,
   output logic                pattern_err,
   output logic                retx_req,
   output logic                chan_fault,
   output logic                tx_seed_load,
   output logic [ERR_W-1:0]    err_count
);

   localparam int         PRE_W     = 4;
   localparam logic [3:0] PATTERN   = 4'b1011;
   localparam int         MAX_FAILS = 4;
   localparam int         LFSR_W    = 4;
   localparam logic [3:0] TAPS      = 4'b1001;
   localparam logic [3:0] SEED      = 4'b1000;

   rx_state_t state;
   logic      sliced;
   logic      load_fire;
   logic      run;
   logic      ref_bit;
   logic      mismatch;

   lnk_slicer #(.SAMPLE_W(SAMPLE_W)) u_slicer (
      .sample    (adc_sample),
      .level     (ref_level),
      .sign_mode (sign_mode),
      .bit_out   (sliced)
   );

   lnk_preamble_fsm #(
      .PRE_W     (PRE_W),
      .PATTERN   (PATTERN),
      .MAX_FAILS (MAX_FAILS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_in      (sliced),
      .load_req    (load_req),
      .state       (state),
      .load_fire   (load_fire),
      .run         (run),
      .pattern_ok  (pattern_ok),
      .pattern_err (pattern_err),
      .retx_req    (retx_req),
      .seed_load   (tx_seed_load)
   );

   lnk_lfsr #(
      .WIDTH    (LFSR_W),
      .TAP_MASK (TAPS),
      .SEED     (SEED)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_fire),
      .advance (run),
      .ref_bit (ref_bit)
   );

   assign mismatch   = run && (sliced != ref_bit);
   assign chan_fault = (state == ST_FAULT);

   lnk_err_counter #(.ERR_W(ERR_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (load_fire),
      .inc   (mismatch),
      .count (err_count)
   );

   AST_COUNT_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load_fire) |=> $stable(err_count)); // R10

   AST_FAULT_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
      chan_fault |=> !pattern_ok); // R6

endmodule

// File: tb/test_prbs_link_rx.sv
module test_prbs_link_rx;

   localparam int ERR_W = 4;
   localparam int CMAX  = (1 << ERR_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [13:0]      adc_sample;
   logic [13:0]      ref_level;
   logic             sign_mode;
   logic             load_req;
   logic             pattern_ok, pattern_err, retx_req, chan_fault, tx_seed_load;
   logic [ERR_W-1:0] err_count;

   int checks   = 0;
   int failures = 0;
   logic [3:0] model;
   int exp_cnt;

   // {sign_mode, sample, ref, expected sliced bit}
   localparam logic [29:0] VEC [8] = '{
      {1'b0, 14'h2001, 14'h2000, 1'b1},
      {1'b0, 14'h2000, 14'h2000, 1'b0},
      {1'b0, 14'h0000, 14'h0000, 1'b0},
      {1'b0, 14'h3FFF, 14'h3FFE, 1'b1},
      {1'b0, 14'h0005, 14'h3000, 1'b0},
      {1'b1, 14'h2000, 14'h3FFF, 1'b1},
      {1'b1, 14'h1FFF, 14'h0000, 1'b0},
      {1'b1, 14'h3FFF, 14'h3FFF, 1'b1}
   };

   always #10 clk = ~clk;

   prbs_link_rx #(.ERR_W(ERR_W)) i_prbs_link_rx (
      .clk, .rst_n, .adc_sample, .ref_level, .sign_mode, .load_req,
      .pattern_ok, .pattern_err, .retx_req, .chan_fault, .tx_seed_load, .err_count
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive_bit(input bit b);
      sign_mode  = 1'b0;
      ref_level  = 14'h2000;
      adc_sample = b ? 14'h3000 : 14'h1000;
      @(negedge clk);
   endtask

   task automatic send_word(input logic [3:0] w);
      for (int i = 3; i >= 0; i--) drive_bit(w[i]);
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      load_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      drive_bit(1'b0); // idle cycle
   endtask

   function automatic logic [3:0] step(input logic [3:0] s);
      return {s[2:0], s[3] ^ s[0]};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; load_req = 1'b0; sign_mode = 1'b0;
      adc_sample = '0; ref_level = '0;
      repeat (3) @(negedge clk);
      // R7 reset state
      check(!pattern_ok && !pattern_err && !retx_req && !chan_fault && !tx_seed_load,
            "R7 flags", {pattern_ok, pattern_err, retx_req, chan_fault, tx_seed_load}, 0);
      check(err_count == 0, "R7 count", err_count, 0);
      rst_n = 1'b1;
      load_req = 1'b1;
      drive_bit(1'b0); // R3 idle cycle
      // R3 reversed word must not match; R8 load ignored in preamble
      send_word(4'b1101);
      check(pattern_err && !pattern_ok, "R5 err set", pattern_err, 1);
      check(retx_req, "R5 retx pulse", retx_req, 1);
      check(!tx_seed_load, "R8 load ignored", tx_seed_load, 0);
      load_req = 1'b0;
      drive_bit(1'b1);
      check(!retx_req, "R5 retx one cycle", retx_req, 0);
      drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1);
      check(pattern_ok && !pattern_err, "R4 ok set", pattern_ok, 1);
      drive_bit(1'b0); drive_bit(1'b1);
      check(!tx_seed_load && pattern_ok, "R8 waiting", tx_seed_load, 0);
      load_req = 1'b1;
      drive_bit(1'b0);
      load_req = 1'b0;
      check(tx_seed_load, "R8 seed pulse", tx_seed_load, 1);
      check(err_count == 0, "R8 count cleared", err_count, 0);
      model = 4'b1000; exp_cnt = 0;
      drive_bit(model[3]); model = step(model);
      check(!tx_seed_load, "R8 pulse one cycle", tx_seed_load, 0);
      for (int i = 1; i < 15; i++) begin
         drive_bit(model[3]); model = step(model);
      end
      check(err_count == 0, "R9 full period clean", err_count, 0);
      for (int i = 0; i < 6; i++) begin
         drive_bit(!model[3]); model = step(model);
      end
      exp_cnt = 6;
      check(err_count == 6, "R10 six errors", err_count, 6);
      load_req = 1'b1;
      drive_bit(model[3]); model = step(model);
      load_req = 1'b0;
      check(!tx_seed_load && err_count == 6, "R8 load ignored in count", tx_seed_load, 0);
      // R1 R2 slicer vectors
      for (int i = 0; i < 8; i++) begin
         sign_mode  = VEC[i][29];
         adc_sample = VEC[i][28:15];
         ref_level  = VEC[i][14:1];
         if (VEC[i][0] != model[3]) exp_cnt++;
         model = step(model);
         @(negedge clk);
         check(err_count == exp_cnt, VEC[i][29] ? "R2 sign slice" : "R1 threshold slice",
               err_count, exp_cnt);
      end
      for (int i = 0; i < 20; i++) begin
         drive_bit(!model[3]); model = step(model);
      end
      check(err_count == CMAX, "R10 saturate", err_count, CMAX);

      // R6 fault on fifth failure
      do_reset();
      for (int k = 0; k < 4; k++) begin
         send_word(4'b0000);
         check(retx_req && !chan_fault, "R5 retry", retx_req, 1);
      end
      send_word(4'b0000);
      check(chan_fault && !retx_req, "R6 fault no retx", chan_fault, 1);
      send_word(4'b1011);
      check(chan_fault && !pattern_ok, "R6 sticky", pattern_ok, 0);

      // R7 reset clears failure tally
      do_reset();
      check(!chan_fault && !pattern_err, "R7 fault cleared", chan_fault, 0);
      for (int k = 0; k < 3; k++) send_word(4'b0110);
      do_reset();
      for (int k = 0; k < 4; k++) send_word(4'b0110);
      check(!chan_fault && retx_req, "R7 tally cleared", chan_fault, 0);
      send_word(4'b0110);
      check(chan_fault, "R6 fifth after reset", chan_fault, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule